// File: doc/BRIEF.md
# Multi-Source Trigger Mode Controller

This block picks the event trigger of a detector readout system from one of four sources, chosen by a two-bit mode input. Two of the sources are internal and periodic: a slow self-trigger used to take pedestal data with no signal, and a faster calibration-rate trigger that also drives a test-mode output which switches the front end to charge injection. The other two come from outside. One is a plain logic-level trigger wire. The other is a trigger message that arrives already parsed on a valid strobe and carries a trigger number and a trigger type.

For every trigger it accepts, the block raises a one-cycle acquisition pulse. It also latches the event record that goes with that pulse: the trigger number, the trigger type and a local sequence count. Triggers that arrive while the readout is busy are dropped. Triggers from any source other than the selected one are also dropped. The sequence count restarts whenever the mode changes.

Top module: `trig_mode_ctrl`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, acq_pulse_o is 0. evt_seq_o, evt_id_o and evt_type_o are 0, and test_mode_o is 0.
- R2: In self-trigger mode (mode code 0), pulses repeat every SELF_PERIOD clock cycles. The first pulse appears SELF_PERIOD+1 rising edges after the edge at which the new mode is first sampled.
- R3: In calibration mode (mode code 1), pulses repeat every CAL_PERIOD clock cycles, with the same first-pulse rule as R2. test_mode_o is 1 in this mode and 0 in every other mode.
- R4: In level-trigger mode (mode code 3), ttl_i passes through a two-stage synchronizer. Each rising edge gives exactly one pulse, visible after the third rising clock edge after the input rises. Holding the input high and letting it fall give no pulse.
- R5: In message mode (mode code 2), a cycle with msg_valid_i high produces a pulse after the next rising edge. msg_id_i and msg_type_i from that cycle appear on evt_id_o and evt_type_o. Back-to-back valid cycles each produce a pulse.
- R6: Triggers from any source other than the one the mode selects have no effect on any output.
- R7: A trigger that arrives in a cycle with busy_i high is ignored. No pulse follows, and the event outputs hold their values.
- R8: The sequence count goes up by one for each accepted trigger. evt_seq_o shows the count including the current event, so the first event after a mode change or a reset reads 1. Events from the internal sources and the level input report evt_id_o = 0 and evt_type_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz in the target) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Trigger source: 0 self, 1 calibration, 2 message, 3 level input |
| busy_i | input | 1 | Readout busy; triggers are dropped while it is high |
| ttl_i | input | 1 | Asynchronous level trigger input |
| msg_valid_i | input | 1 | Parsed trigger message strobe |
| msg_id_i | input | ID_W | Trigger number of the message |
| msg_type_i | input | TYPE_W | Trigger type of the message |
| acq_pulse_o | output | 1 | One-cycle acquisition pulse per accepted trigger |
| test_mode_o | output | 1 | Front-end test-mode select, high in calibration mode |
| evt_id_o | output | ID_W | Latched trigger number of the last event |
| evt_type_o | output | TYPE_W | Latched trigger type of the last event |
| evt_seq_o | output | SEQ_W | Latched local sequence count of the last event |

## Verification
The defaults of 400000 and 2000 cycles stand for 50 Hz and 10 kHz at 20 MHz. The bench instead builds the block with SELF_PERIOD = 50 and CAL_PERIOD = 12, so that several full periods and the exact first-pulse delay of both internal sources can be measured cycle by cycle. The ID and type widths stay at their defaults of 16 and 8, and SEQ_W stays at 32. This lets the bench check exact latched message values and sequence restarts across every mode change.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    MODE_SELF   = 2'd0,
    MODE_CAL    = 2'd1,
    MODE_SERIAL = 2'd2,
    MODE_TTL    = 2'd3
  } trig_mode_e;

  localparam int unsigned NUM_PERIODIC = 2;
  localparam int unsigned PER_SELF_IDX = 0;
  localparam int unsigned PER_CAL_IDX  = 1;

endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R4

endmodule

// File: rtl/trig_period_gen.sv
module trig_period_gen #(
  parameter int unsigned PERIOD = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);

  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (!en_i)       cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = en_i & at_last;

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R2

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < PERIOD); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_q == '0); // R2

endmodule

// File: rtl/trig_event_reg.sv
module trig_event_reg #(
  parameter int unsigned SEQ_W  = 32,
  parameter int unsigned ID_W   = 16,
  parameter int unsigned TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              clear_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic              pulse_o,
  output logic [ID_W-1:0]   id_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [SEQ_W-1:0]  seq_o
);

  logic [SEQ_W-1:0]  seq_q, seq_d, seq_inc;
  logic              pulse_q, pulse_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic [TYPE_W-1:0] type_q, type_d;
  logic [SEQ_W-1:0]  seqo_q, seqo_d;

  assign seq_inc = seq_q + 1'b1;

  always_comb begin
    pulse_d = accept_i;
    id_d    = id_q;
    type_d  = type_q;
    seqo_d  = seqo_q;
    seq_d   = seq_q;
    if (clear_i) begin
      seq_d = '0;
    end else if (accept_i) begin
      seq_d  = seq_inc;
      seqo_d = seq_inc;
      id_d   = id_i;
      type_d = type_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= '0;
      pulse_q <= 1'b0;
      id_q    <= '0;
      type_q  <= '0;
      seqo_q  <= '0;
    end else begin
      seq_q   <= seq_d;
      pulse_q <= pulse_d;
      id_q    <= id_d;
      type_q  <= type_d;
      seqo_q  <= seqo_d;
    end
  end

  assign pulse_o = pulse_q;
  assign id_o    = id_q;
  assign type_o  = type_q;
  assign seq_o   = seqo_q;

  AST_SEQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> seq_q == '0); // R8

  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !accept_i) |=> $stable(seq_q) && $stable(seqo_q)); // R7

  AST_PULSE_SEQ_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> seq_o != '0); // R8

endmodule

// File: rtl/trig_mode_ctrl.sv
module trig_mode_ctrl
  import trig_pkg::*;
#(
  parameter int unsigned SELF_PERIOD = 400000,
  parameter int unsigned CAL_PERIOD  = 2000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEQ_W       = 32,
  parameter int unsigned ID_W        = 16,
  parameter int unsigned TYPE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              busy_i,
  input  logic              ttl_i,
  input  logic              msg_valid_i,
  input  logic [ID_W-1:0]   msg_id_i,
  input  logic [TYPE_W-1:0] msg_type_i,
  output logic              acq_pulse_o,
  output logic              test_mode_o,
  output logic [ID_W-1:0]   evt_id_o,
  output logic [TYPE_W-1:0] evt_type_o,
  output logic [SEQ_W-1:0]  evt_seq_o
);

  logic       rst_ns;
  trig_mode_e mode_q, mode_d, mode_req;
  logic       mode_chg;
  logic [NUM_PERIODIC-1:0] per_en;
  logic [NUM_PERIODIC-1:0] per_tick;
  logic       ttl_rise;
  logic       src_hit;
  logic       accept;
  logic [ID_W-1:0]   sel_id;
  logic [TYPE_W-1:0] sel_type;

  trig_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_ns)
  );

  assign mode_req = trig_mode_e'(mode_i);
  assign mode_chg = (mode_req != mode_q);

  always_comb begin
    mode_d = mode_req;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) mode_q <= MODE_SELF;
    else         mode_q <= mode_d;
  end

  assign per_en[PER_SELF_IDX] = (mode_q == MODE_SELF) && !mode_chg;
  assign per_en[PER_CAL_IDX]  = (mode_q == MODE_CAL)  && !mode_chg;

  for (genvar g = 0; g < NUM_PERIODIC; g++) begin : g_per
    localparam int unsigned P = (g == PER_SELF_IDX) ? SELF_PERIOD : CAL_PERIOD;
    trig_period_gen #(.PERIOD(P)) u_gen (
      .clk    (clk),
      .rst_n  (rst_ns),
      .en_i   (per_en[g]),
      .tick_o (per_tick[g])
    );
  end

  trig_edge_sync #(.STAGES(SYNC_STAGES)) u_ttl (
    .clk     (clk),
    .rst_n   (rst_ns),
    .async_i (ttl_i),
    .rise_o  (ttl_rise)
  );

  always_comb begin
    src_hit  = 1'b0;
    sel_id   = '0;
    sel_type = '0;
    unique case (mode_q)
      MODE_SELF:   src_hit = per_tick[PER_SELF_IDX];
      MODE_CAL:    src_hit = per_tick[PER_CAL_IDX];
      MODE_SERIAL: begin
        src_hit  = msg_valid_i;
        sel_id   = msg_id_i;
        sel_type = msg_type_i;
      end
      MODE_TTL:    src_hit = ttl_rise;
      default:     src_hit = 1'b0;
    endcase
  end

  assign accept = src_hit && !busy_i && !mode_chg;

  trig_event_reg #(.SEQ_W(SEQ_W), .ID_W(ID_W), .TYPE_W(TYPE_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_ns),
    .accept_i (accept),
    .clear_i  (mode_chg),
    .id_i     (sel_id),
    .type_i   (sel_type),
    .pulse_o  (acq_pulse_o),
    .id_o     (evt_id_o),
    .type_o   (evt_type_o),
    .seq_o    (evt_seq_o)
  );

  assign test_mode_o = (mode_q == MODE_CAL);

  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_ns)
    busy_i |=> !acq_pulse_o); // R7

  AST_MSG_LATCH: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_q == MODE_SERIAL && !mode_chg && msg_valid_i && !busy_i)
      |=> acq_pulse_o && evt_id_o == $past(msg_id_i) && evt_type_o == $past(msg_type_i)); // R5

  AST_MODE_CHG_NOPULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    mode_chg |=> !acq_pulse_o); // R6

endmodule

// File: tb/tb_trig_mode_ctrl.sv
module tb_trig_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int SELF_P = 50;
  localparam int CAL_P  = 12;
  localparam int WATCHDOG = 20000;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        busy_i;
  logic        ttl_i;
  logic        msg_valid_i;
  logic [15:0] msg_id_i;
  logic [7:0]  msg_type_i;
  logic        acq_pulse_o;
  logic        test_mode_o;
  logic [15:0] evt_id_o;
  logic [7:0]  evt_type_o;
  logic [31:0] evt_seq_o;

  int n_total = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  trig_mode_ctrl #(.SELF_PERIOD(SELF_P), .CAL_PERIOD(CAL_P)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .busy_i(busy_i), .ttl_i(ttl_i),
    .msg_valid_i(msg_valid_i), .msg_id_i(msg_id_i), .msg_type_i(msg_type_i),
    .acq_pulse_o(acq_pulse_o), .test_mode_o(test_mode_o), .evt_id_o(evt_id_o),
    .evt_type_o(evt_type_o), .evt_seq_o(evt_seq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      n_total++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d limit=%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_pulse(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!acq_pulse_o && n < limit);
  endtask

  task automatic count_pulses(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (acq_pulse_o) cnt++;
    end
  endtask

  task automatic send_msg(input logic [15:0] id, input logic [7:0] ty);
    msg_valid_i = 1'b1;
    msg_id_i    = id;
    msg_type_i  = ty;
    @(negedge clk);
    msg_valid_i = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_i = m;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode_i = 2'd3; busy_i = 1'b0; ttl_i = 1'b0;
    msg_valid_i = 1'b0; msg_id_i = '0; msg_type_i = '0;
    repeat (3) @(negedge clk);
    chk(acq_pulse_o == 1'b0 && test_mode_o == 1'b0, "R1", "outputs in reset",
        {acq_pulse_o, test_mode_o}, 0);
    chk(evt_seq_o == 0 && evt_id_o == 0 && evt_type_o == 0, "R1", "event fields in reset",
        evt_seq_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(acq_pulse_o == 1'b0 && evt_seq_o == 0, "R1", "after release", evt_seq_o, 0);
  endtask

  task automatic t_ttl();
    int n, c;
    ttl_i = 1'b1;
    wait_pulse(10, n);
    chk(n == 3, "R4", "ttl latency", n, 3);
    chk(evt_seq_o == 1, "R8", "first ttl seq", evt_seq_o, 1);
    chk(evt_id_o == 0 && evt_type_o == 0, "R8", "ttl id/type zero", evt_id_o, 0);
    count_pulses(10, c);
    chk(c == 0, "R4", "held high no extra pulse", c, 0);
    ttl_i = 1'b0;
    count_pulses(8, c);
    chk(c == 0, "R4", "falling edge no pulse", c, 0);
    ttl_i = 1'b1;
    count_pulses(8, c);
    chk(c == 1, "R4", "second rise one pulse", c, 1);
    chk(evt_seq_o == 2, "R8", "ttl seq step", evt_seq_o, 2);
  endtask

  task automatic t_ignore_in_ttl();
    int c;
    send_msg(16'h7777, 8'h77);
    count_pulses(6, c);
    chk(c == 0, "R6", "message ignored in level mode", c, 0);
    chk(evt_id_o == 0 && evt_seq_o == 2, "R6", "fields untouched by message", evt_id_o, 0);
    ttl_i = 1'b0;
    repeat (4) @(negedge clk);
    ttl_i = 1'b1;
    count_pulses(8, c);
    chk(c == 1 && evt_seq_o == 3, "R8", "seq continues", evt_seq_o, 3);
    ttl_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_serial();
    int c;
    set_mode(2'd2);
    ttl_i = 1'b1;
    count_pulses(8, c);
    chk(c == 0, "R6", "level edge ignored in message mode", c, 0);
    ttl_i = 1'b0;
    msg_valid_i = 1'b1; msg_id_i = 16'h1234; msg_type_i = 8'h5A;
    @(negedge clk);
    msg_valid_i = 1'b0;
    chk(acq_pulse_o == 1'b1, "R5", "message pulse next edge", acq_pulse_o, 1);
    chk(evt_id_o == 16'h1234 && evt_type_o == 8'h5A, "R5", "message id latched",
        evt_id_o, 16'h1234);
    chk(evt_seq_o == 1, "R8", "seq cleared by mode change", evt_seq_o, 1);
    @(negedge clk);
    chk(acq_pulse_o == 1'b0, "R5", "pulse one cycle", acq_pulse_o, 0);
    msg_valid_i = 1'b1; msg_id_i = 16'hBEEF; msg_type_i = 8'h03;
    @(negedge clk);
    chk(acq_pulse_o && evt_id_o == 16'hBEEF && evt_seq_o == 2, "R5", "first of pair",
        evt_seq_o, 2);
    msg_id_i = 16'h0042; msg_type_i = 8'hC1;
    @(negedge clk);
    msg_valid_i = 1'b0;
    chk(acq_pulse_o && evt_id_o == 16'h0042 && evt_type_o == 8'hC1 && evt_seq_o == 3,
        "R5", "second of pair", evt_seq_o, 3);
  endtask

  task automatic t_busy();
    int c;
    busy_i = 1'b1;
    send_msg(16'h9999, 8'h99);
    count_pulses(4, c);
    chk(c == 0 && acq_pulse_o == 1'b0, "R7", "busy drops message", c, 0);
    chk(evt_id_o == 16'h0042 && evt_seq_o == 3, "R7", "busy keeps fields", evt_seq_o, 3);
    busy_i = 1'b0;
    send_msg(16'h0101, 8'h02);
    chk(acq_pulse_o && evt_seq_o == 4 && evt_id_o == 16'h0101, "R7", "accepted after busy",
        evt_seq_o, 4);
  endtask

  task automatic t_cal();
    int n, c;
    mode_i = 2'd1;
    @(negedge clk);
    chk(test_mode_o == 1'b1, "R3", "test mode on", test_mode_o, 1);
    wait_pulse(CAL_P + 10, n);
    chk(n == CAL_P, "R3", "first cal pulse", n + 1, CAL_P + 1);
    chk(evt_seq_o == 1 && evt_id_o == 0 && evt_type_o == 0, "R8", "cal event fields",
        evt_seq_o, 1);
    wait_pulse(CAL_P + 10, n);
    chk(n == CAL_P, "R3", "cal period", n, CAL_P);
    busy_i = 1'b1;
    count_pulses(2 * CAL_P + 1, c);
    busy_i = 1'b0;
    chk(c == 0 && evt_seq_o == 2, "R7", "busy drops periodic", c, 0);
  endtask

  task automatic t_self();
    int n, c;
    mode_i = 2'd0;
    @(negedge clk);
    chk(test_mode_o == 1'b0, "R3", "test mode off in self mode", test_mode_o, 0);
    wait_pulse(SELF_P + 10, n);
    chk(n + 1 == SELF_P + 1, "R2", "first self pulse", n + 1, SELF_P + 1);
    chk(evt_seq_o == 1, "R8", "self seq restart", evt_seq_o, 1);
    send_msg(16'h5555, 8'h55);
    wait_pulse(SELF_P + 10, n);
    chk(n + 1 == SELF_P, "R2", "self period", n + 1, SELF_P);
    chk(evt_id_o == 0 && evt_seq_o == 2, "R6", "message ignored in self mode", evt_id_o, 0);
    count_pulses(SELF_P - 1, c);
    chk(c == 0, "R2", "no pulse inside period", c, 0);
  endtask

  initial begin
    t_reset();
    t_ttl();
    t_ignore_in_ttl();
    t_serial();
    t_busy();
    t_cal();
    t_self();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

endmodule